// File: doc/BRIEF.md
# Switching Period Hysteresis Enable Counter

This block watches a train of qualified power-cycle pulses and measures, in clock cycles, the spacing between each pulse and the one before it. From those measured periods it decides whether a downstream rectifier controller should run. The decision is reported on a single pull-down request flag. When the flag is low, the external open-drain switch is off and the controller stays enabled. When the flag is high, the switch is on and the controller is parked.

The decision is deliberately lopsided. To park the controller, the switching frequency has to stay low for a long, unbroken run of periods. To wake it again, only a modest number of fast periods is needed, and they may be scattered among slow ones. Both period limits are programmable inputs, and the enable limit is set below the disable limit so that the two transitions have hysteresis between them. The running period timer and both transition counts are brought out as ports for test.

Top module: `sw_period_hyst`

## Requirements
- R1: While `rst` is high, or in any cycle after a cycle in which `enable` was low, `pull_down` is 0 and `period_cnt`, `park_cnt` and `wake_cnt` are all 0.
- R2: With `pull_down` at 0, the 63rd consecutive measured period that is strictly greater than `dis_thresh` sets `pull_down` to 1. The flag is visible in the cycle after that pulse.
- R3: With `pull_down` at 0, a measured period that is less than or equal to `dis_thresh` clears `park_cnt` to 0.
- R4: With `pull_down` at 1, the 32nd cumulative measured period that is strictly less than `en_thresh` returns `pull_down` to 0 in the cycle after that pulse.
- R5: With `pull_down` at 1, a measured period that is greater than or equal to `en_thresh` leaves `wake_cnt` unchanged.
- R6: A qualified pulse while armed loads `period_cnt` with 1. Each following cycle adds 1, and the value saturates at all ones. The period measured at a pulse is the `period_cnt` value in that cycle, so a saturated timer counts as a period longer than any `dis_thresh` below all ones.
- R7: The first pulse after `enable` rises (or after reset) only arms the timer: no period is evaluated and the counts do not change. Until then, `period_cnt` stays 0.
- R8: Setting `pull_down` clears both counts, and so does clearing it. `wake_cnt` is 0 whenever `pull_down` is 0, and `park_cnt` is 0 whenever `pull_down` is 1.
- R9: In a cycle with `pulse` low, neither `park_cnt` nor `wake_cnt` changes in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable; low holds the power-up state |
| pulse | input | 1 | One-cycle qualified power-cycle pulse |
| dis_thresh | input | TIMER_W | Period limit, in cycles, above which a period counts toward parking |
| en_thresh | input | TIMER_W | Period limit, in cycles, below which a period counts toward waking |
| pull_down | output | 1 | 1 requests the external switch on (controller parked) |
| period_cnt | output | TIMER_W | Running period timer |
| park_cnt | output | $clog2(PARK_RUN+1) | Consecutive long-period count |
| wake_cnt | output | $clog2(WAKE_TOTAL+1) | Cumulative short-period count |

## Verification
The hardest situation to reach is the one where the parked state sees fast periods mixed with slow ones and with periods that fall between the two limits. In that state the wake count must only grow and must never be cleared. Getting there means first driving 63 unbroken long periods. The stimulus table does this, then places short, long, in-between and exactly-at-limit gaps in sequence and checks the count after each group. The saturated timer is reached by leaving a gap of several hundred cycles with an 8-bit timer. The arming rule is reached by dropping `enable` and then sending a lone pulse.

// File: rtl/sph_pkg.sv
package sph_pkg;

    typedef enum logic {
        MODE_RUN    = 1'b0,
        MODE_PARKED = 1'b1
    } sph_mode_e;

    typedef struct packed {
        logic valid;
        logic is_long;
        logic is_short;
    } sph_class_t;

    function automatic logic sph_gt(input logic [31:0] a, input logic [31:0] b);
        return a > b;
    endfunction

endpackage

// File: rtl/sph_period_timer.sv
module sph_period_timer #(
    parameter int TIMER_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               pulse,
    output logic               sample_valid,
    output logic [TIMER_W-1:0] period
);
    localparam logic [TIMER_W-1:0] T_MAX = '1;

    logic               armed;
    logic [TIMER_W-1:0] timer;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            armed <= 1'b0;
            timer <= '0;
        end else if (pulse) begin
            armed <= 1'b1;
            timer <= TIMER_W'(1);
        end else if (armed && timer != T_MAX) begin
            timer <= timer + TIMER_W'(1);
        end
    end

    assign sample_valid = pulse && armed && !clr;
    assign period       = timer;
endmodule

// File: rtl/sph_classifier.sv
module sph_classifier
    import sph_pkg::*;
#(
    parameter int TIMER_W = 16
) (
    input  logic               sample_valid,
    input  logic [TIMER_W-1:0] period,
    input  logic [TIMER_W-1:0] dis_thresh,
    input  logic [TIMER_W-1:0] en_thresh,
    output sph_class_t         cls
);
    always_comb begin
        cls.valid    = sample_valid;
        cls.is_long  = sph_gt(32'(period), 32'(dis_thresh));
        cls.is_short = sph_gt(32'(en_thresh), 32'(period));
    end
endmodule

// File: rtl/sph_hyst_ctrl.sv
module sph_hyst_ctrl
    import sph_pkg::*;
#(
    parameter int PARK_RUN   = 63,
    parameter int WAKE_TOTAL = 32,
    localparam int PW = $clog2(PARK_RUN + 1),
    localparam int WW = $clog2(WAKE_TOTAL + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  sph_class_t    cls,
    output logic          pull_down,
    output logic [PW-1:0] park_cnt,
    output logic [WW-1:0] wake_cnt
);
    localparam logic [PW-1:0] PARK_LAST = PW'(PARK_RUN - 1);
    localparam logic [WW-1:0] WAKE_LAST = WW'(WAKE_TOTAL - 1);

    sph_mode_e mode;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            mode     <= MODE_RUN;
            park_cnt <= '0;
            wake_cnt <= '0;
        end else if (cls.valid) begin
            unique case (mode)
                MODE_RUN: begin
                    if (!cls.is_long) begin
                        park_cnt <= '0;
                    end else if (park_cnt == PARK_LAST) begin
                        mode     <= MODE_PARKED;
                        park_cnt <= '0;
                        wake_cnt <= '0;
                    end else begin
                        park_cnt <= park_cnt + PW'(1);
                    end
                end
                MODE_PARKED: begin
                    if (cls.is_short) begin
                        if (wake_cnt == WAKE_LAST) begin
                            mode     <= MODE_RUN;
                            park_cnt <= '0;
                            wake_cnt <= '0;
                        end else begin
                            wake_cnt <= wake_cnt + WW'(1);
                        end
                    end
                end
                default: mode <= MODE_RUN;
            endcase
        end
    end

    assign pull_down = (mode == MODE_PARKED);
endmodule

// File: rtl/sw_period_hyst.sv
module sw_period_hyst
    import sph_pkg::*;
#(
    parameter int TIMER_W    = 16,
    parameter int PARK_RUN   = 63,
    parameter int WAKE_TOTAL = 32
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              enable,
    input  logic                              pulse,
    input  logic [TIMER_W-1:0]                dis_thresh,
    input  logic [TIMER_W-1:0]                en_thresh,
    output logic                              pull_down,
    output logic [TIMER_W-1:0]                period_cnt,
    output logic [$clog2(PARK_RUN+1)-1:0]     park_cnt,
    output logic [$clog2(WAKE_TOTAL+1)-1:0]   wake_cnt
);
    logic               clr;
    logic               sample_valid;
    logic [TIMER_W-1:0] period;
    sph_class_t         cls;

    assign clr = !enable;

    sph_period_timer #(.TIMER_W(TIMER_W)) u_timer (
        .clk          (clk),
        .rst          (rst),
        .clr          (clr),
        .pulse        (pulse),
        .sample_valid (sample_valid),
        .period       (period)
    );

    sph_classifier #(.TIMER_W(TIMER_W)) u_class (
        .sample_valid (sample_valid),
        .period       (period),
        .dis_thresh   (dis_thresh),
        .en_thresh    (en_thresh),
        .cls          (cls)
    );

    sph_hyst_ctrl #(.PARK_RUN(PARK_RUN), .WAKE_TOTAL(WAKE_TOTAL)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .cls       (cls),
        .pull_down (pull_down),
        .park_cnt  (park_cnt),
        .wake_cnt  (wake_cnt)
    );

    assign period_cnt = period;
endmodule

// File: rtl/sw_period_hyst_chk.sv
module sw_period_hyst_chk #(
    parameter int TIMER_W    = 16,
    parameter int PARK_RUN   = 63,
    parameter int WAKE_TOTAL = 32,
    localparam int PW = $clog2(PARK_RUN + 1),
    localparam int WW = $clog2(WAKE_TOTAL + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic               enable,
    input logic               pulse,
    input logic               pull_down,
    input logic [TIMER_W-1:0] period_cnt,
    input logic [PW-1:0]      park_cnt,
    input logic [WW-1:0]      wake_cnt
);
    localparam logic [TIMER_W-1:0] T_MAX = '1;

    p_disabled_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!pull_down && park_cnt == '0 && wake_cnt == '0 && period_cnt == '0));

    p_park_needs_run_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(pull_down) |-> ($past(pulse) && $past(park_cnt) == PW'(PARK_RUN - 1)));

    p_wake_needs_total_r4: assert property (@(posedge clk) disable iff (rst)
        ($fell(pull_down) && $past(enable)) |-> ($past(pulse) && $past(wake_cnt) == WW'(WAKE_TOTAL - 1)));

    p_wake_never_drops_r5: assert property (@(posedge clk) disable iff (rst)
        (pull_down && enable) |=> (!pull_down || wake_cnt >= $past(wake_cnt)));

    p_timer_step_r6: assert property (@(posedge clk) disable iff (rst)
        (enable && !pulse && period_cnt != '0 && period_cnt != T_MAX)
            |=> (period_cnt == $past(period_cnt) + TIMER_W'(1)));

    p_timer_restart_r6: assert property (@(posedge clk) disable iff (rst)
        (enable && pulse) |=> (period_cnt == TIMER_W'(1)));

    p_opposite_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (pull_down ? park_cnt == '0 : wake_cnt == '0));

    p_quiet_counts_r9: assert property (@(posedge clk) disable iff (rst)
        (enable && !pulse) |=> ($stable(park_cnt) && $stable(wake_cnt) && $stable(pull_down)));
endmodule

bind sw_period_hyst sw_period_hyst_chk #(
    .TIMER_W    (TIMER_W),
    .PARK_RUN   (PARK_RUN),
    .WAKE_TOTAL (WAKE_TOTAL)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .pulse      (pulse),
    .pull_down  (pull_down),
    .period_cnt (period_cnt),
    .park_cnt   (park_cnt),
    .wake_cnt   (wake_cnt)
);

// File: tb/tb_sw_period_hyst.sv
module tb_sw_period_hyst;
    localparam int TW = 8;
    localparam int PR = 63;
    localparam int WT = 32;
    localparam int PW = $clog2(PR + 1);
    localparam int WW = $clog2(WT + 1);
    localparam int DIS = 20;
    localparam int ENT = 10;

    typedef struct packed {
        int gap;
        int reps;
        int pd;
        int park;
        int wake;
        int req;
    } vec_t;

    // gap, repetitions, expected pull_down, park_cnt, wake_cnt, requirement
    localparam vec_t VEC [11] = '{
        '{25, 62, 0, 62,  0, 2},  // R2: one short of parking
        '{15,  1, 0,  0,  0, 3},  // R3: in-between period breaks the run
        '{25, 63, 1,  0,  0, 2},  // R2 and R8: full run parks
        '{ 5, 20, 1,  0, 20, 4},  // R4: fast periods accumulate
        '{30, 10, 1,  0, 20, 5},  // R5: slow periods keep the count
        '{15,  3, 1,  0, 20, 5},  // R5: in-between periods keep the count
        '{10,  1, 1,  0, 20, 5},  // R5: equal to en_thresh is not short
        '{ 9, 11, 1,  0, 31, 4},  // R4: one short of waking
        '{ 9,  1, 0,  0,  0, 4},  // R4 and R8: 32nd short period wakes
        '{20,  5, 0,  0,  0, 3},  // R3: equal to dis_thresh is not long
        '{21,  3, 0,  3,  0, 2}   // R2: just above dis_thresh counts
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          enable = 1'b1;
    logic          pulse = 1'b0;
    logic [TW-1:0] dis_thresh = TW'(DIS);
    logic [TW-1:0] en_thresh = TW'(ENT);
    logic          pull_down;
    logic [TW-1:0] period_cnt;
    logic [PW-1:0] park_cnt;
    logic [WW-1:0] wake_cnt;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sw_period_hyst #(.TIMER_W(TW), .PARK_RUN(PR), .WAKE_TOTAL(WT)) dut (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .pulse      (pulse),
        .dis_thresh (dis_thresh),
        .en_thresh  (en_thresh),
        .pull_down  (pull_down),
        .period_cnt (period_cnt),
        .park_cnt   (park_cnt),
        .wake_cnt   (wake_cnt)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fire();
        pulse = 1'b1;
        @(negedge clk);
        pulse = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        tick(4);
        // R1: reset state
        check("R1", "pull_down in reset", int'(pull_down), 0);
        check("R1", "period_cnt in reset", int'(period_cnt), 0);
        rst = 1'b0;
        tick(3);
        // R7: not armed yet, timer idle
        check("R7", "period_cnt before first pulse", int'(period_cnt), 0);
        fire();
        check("R7", "park_cnt after arming pulse", int'(park_cnt), 0);
        check("R6", "period_cnt after pulse", int'(period_cnt), 1);

        for (int i = 0; i < 11; i++) begin
            string tag;
            tag = $sformatf("R%0d", VEC[i].req);
            for (int k = 0; k < VEC[i].reps; k++) begin
                tick(VEC[i].gap - 1);
                fire();
            end
            check(tag, $sformatf("vec %0d pull_down", i), int'(pull_down), VEC[i].pd);
            check(tag, $sformatf("vec %0d park_cnt", i), int'(park_cnt), VEC[i].park);
            check(tag, $sformatf("vec %0d wake_cnt", i), int'(wake_cnt), VEC[i].wake);
        end

        // R9: a long quiet stretch leaves the counts alone
        tick(30);
        check("R9", "park_cnt without pulses", int'(park_cnt), 3);
        check("R9", "wake_cnt without pulses", int'(wake_cnt), 0);

        // R6: timer saturates and still counts as long
        tick(400);
        check("R6", "saturated period_cnt", int'(period_cnt), 255);
        fire();
        check("R6", "park_cnt after saturated period", int'(park_cnt), 4);
        check("R6", "period_cnt restart", int'(period_cnt), 1);

        // R1: dropping enable returns to power-up state
        tick(5);
        enable = 1'b0;
        tick(1);
        check("R1", "park_cnt after disable", int'(park_cnt), 0);
        check("R1", "period_cnt after disable", int'(period_cnt), 0);
        check("R1", "pull_down after disable", int'(pull_down), 0);
        enable = 1'b1;
        tick(40);
        // R7: first pulse after re-enable only arms
        check("R7", "period_cnt idle after re-enable", int'(period_cnt), 0);
        fire();
        check("R7", "park_cnt after arming pulse", int'(park_cnt), 0);
        check("R7", "period_cnt after arming pulse", int'(period_cnt), 1);
        tick(29);
        fire();
        check("R2", "park_cnt after first timed long period", int'(park_cnt), 1);

        tick(3);
        finish_run();
    end
endmodule